// File: doc/BRIEF.md
# Password-Guarded Init-Lock Watchdog

This block holds the system's "initialization finished" flag. While the flag is 1, other registers on the chip that depend on it stay write-locked. To change it, software must make two writes to the control register, in order. The first is a key write that copies two mirror bits from a second register. The second is a change write that carries the new flag value. A write that breaks the sequence is dropped. It also sets a sticky error flag and asks for a watchdog reset.

A 16-bit watchdog down-counter runs alongside the flag. With the flag set, every change write reloads the counter from a programmable reload field. Clearing the flag puts the counter into a short time-out mode with a fixed period. Software must set the flag again before that period ends. When the counter reaches zero in either mode, the block pulses a reset request for one cycle.

Both control registers can be read back over a simple register port. Software uses this to poll the flag after it asks for the flag to be cleared.

Top module: `wdt_initlock`

## Requirements
- R1: After reset the init flag is 1, the key window is closed (the lock bit reads 1), the mirror bits and the error flag are 0, `prot_lock` is 1 and `rst_req` is 0.
- R2: A key write goes to address 0. It is accepted only when the window is closed and all of these hold: bits 7:4 are 1111b, bit 1 is 0, bit 3 equals the stored mirror bit DR and bit 2 equals the stored mirror bit IR. An accepted key write opens the window, so bit 1 of address 0 reads 0.
- R3: The window closes on the next write to address 0, whatever that write holds. Writes to other addresses leave the window as it is.
- R4: While the window is open, a write to address 0 is a valid change write when bits 7:4 are 1111b, bit 1 is 1 and bits 3:2 are 00b. A valid change write stores bit 0 as the new init flag and bits 31:16 as the reload field, and clears the error flag.
- R5: Any other write to address 0 changes neither the init flag nor the reload field. This covers a bad key, a bad change write, and a change write sent without a key first. Such a write sets the error flag (bit 8 of address 0) and raises `rst_req` for one cycle, in the cycle after the write edge.
- R6: Address 1 holds DR in bit 3 and IR in bit 2. These bits can be written only while the init flag is 0. Writes while the flag is 1 are ignored.
- R7: `prot_lock` equals the stored init flag and changes only through a valid change write.
- R8: A valid change write with bit 0 = 0 loads the counter with TMO_PERIOD. After that write edge, `rst_req` stays low for TMO_PERIOD further edges and is high only after edge TMO_PERIOD+1.
- R9: A valid change write with bit 0 = 1 loads the counter with its new reload field. With reload value N, `rst_req` pulses after edge N+1.
- R10: Read data is registered, one cycle after the address. Address 0 reads init flag (bit 0), lock (bit 1), error (bit 8) and reload field (bits 31:16). Address 1 reads DR and IR in bits 3:2. Every other bit, and every other address, reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| prot_lock | output | 1 | Lock for the protected registers (the init flag) |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest states to reach are those that depend on both the mirror bits and the window at once. One is a key write that is correct except that it carries stale mirror values. The other is a second key write sent while the window is already open. The stimulus reaches them in order. It first clears the flag and programs DR and IR, which only works while the flag is 0. It then sends the old key, which must now fail, and after that the new key. The time-out expiry is measured edge by edge right after the clearing write, so the exact cycle of the pulse is checked and not only that a pulse occurs.

// File: rtl/wdt_initlock_pkg.sv
package wdt_initlock_pkg;
  localparam int unsigned ADDR_CTRL0 = 0;
  localparam int unsigned ADDR_CTRL1 = 1;
  localparam int unsigned BIT_FLAG   = 0;
  localparam int unsigned BIT_LOCK   = 1;
  localparam int unsigned BIT_IR     = 2;
  localparam int unsigned BIT_DR     = 3;
  localparam int unsigned BIT_ERR    = 8;
  localparam logic [3:0]  KEY_NIB    = 4'hF;

  typedef enum logic {PH_IDLE = 1'b0, PH_OPEN = 1'b1} phase_t;
endpackage

// File: rtl/wdt_access_seq.sv
module wdt_access_seq
  import wdt_initlock_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 16,
  parameter logic [CNT_W-1:0] RLD_INIT = '1,
  parameter logic [CNT_W-1:0] TMO_PERIOD = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              flag_q,
  output logic              win_open,
  output logic              err_q,
  output logic              dr_q,
  output logic              ir_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              err_evt,
  output logic              load_evt,
  output logic [CNT_W-1:0]  load_val
);
  localparam int unsigned RLD_LSB = DATA_W - CNT_W;

  phase_t phase_q;
  logic wr0, wr1, key_ok, pw_ok, mod_ok, good_pw, good_mod;

  always_comb begin
    wr0      = we && (addr == ADDR_W'(ADDR_CTRL0));
    wr1      = we && (addr == ADDR_W'(ADDR_CTRL1));
    key_ok   = (wdata[7:4] == KEY_NIB);
    pw_ok    = key_ok && !wdata[BIT_LOCK] && (wdata[BIT_DR] == dr_q) && (wdata[BIT_IR] == ir_q);
    mod_ok   = key_ok && wdata[BIT_LOCK] && (wdata[BIT_DR:BIT_IR] == 2'b00);
    good_pw  = wr0 && (phase_q == PH_IDLE) && pw_ok;
    good_mod = wr0 && (phase_q == PH_OPEN) && mod_ok;
    err_evt  = wr0 && !good_pw && !good_mod;
    load_evt = good_mod;
    load_val = wdata[BIT_FLAG] ? wdata[DATA_W-1:RLD_LSB] : TMO_PERIOD;
  end

  assign win_open = (phase_q == PH_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PH_IDLE;
      flag_q   <= 1'b1;
      err_q    <= 1'b0;
      dr_q     <= 1'b0;
      ir_q     <= 1'b0;
      reload_q <= RLD_INIT;
    end else begin
      if (wr0) phase_q <= good_pw ? PH_OPEN : PH_IDLE;
      if (good_mod) begin
        flag_q   <= wdata[BIT_FLAG];
        reload_q <= wdata[DATA_W-1:RLD_LSB];
        err_q    <= 1'b0;
      end
      if (err_evt) err_q <= 1'b1;
      if (wr1 && !flag_q) begin
        dr_q <= wdata[BIT_DR];
        ir_q <= wdata[BIT_IR];
      end
    end
  end

  assert_window_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (win_open && we && addr == ADDR_W'(ADDR_CTRL0)) |=> !win_open);
  assert_mirror_locked_R6: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_W'(ADDR_CTRL1) && flag_q) |=> $stable({dr_q, ir_q}));
  assert_flag_needs_window_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(flag_q) |-> $past(win_open));
  assert_bad_write_keeps_reload_R5: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> ($stable(reload_q) && $stable(flag_q) && err_q));
endmodule

// File: rtl/wdt_tmo_counter.sv
module wdt_tmo_counter #(
  parameter int unsigned CNT_W = 16,
  parameter logic [CNT_W-1:0] CNT_INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = (cnt_q == '0) && !load;

  always_ff @(posedge clk) begin
    if (rst)           cnt_q <= CNT_INIT;
    else if (load)     cnt_q <= load_val;
    else if (expire)   cnt_q <= period;
    else               cnt_q <= cnt_q - 1'b1;
  end

  assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
  assert_load_value_R9: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdt_initlock.sv
module wdt_initlock
  import wdt_initlock_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned CNT_W  = 16,
  parameter logic [CNT_W-1:0] RLD_INIT = '1,
  parameter logic [CNT_W-1:0] TMO_PERIOD = 16'h0400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              prot_lock,
  output logic              rst_req
);
  localparam int unsigned RLD_LSB = DATA_W - CNT_W;

  logic flag_q, win_open, err_q, dr_q, ir_q, err_evt, load_evt, expire;
  logic [CNT_W-1:0] reload_q, load_val, period;
  logic [DATA_W-1:0] rd_next;

  wdt_access_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .RLD_INIT(RLD_INIT), .TMO_PERIOD(TMO_PERIOD)
  ) u_seq (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .flag_q(flag_q), .win_open(win_open), .err_q(err_q), .dr_q(dr_q), .ir_q(ir_q),
    .reload_q(reload_q), .err_evt(err_evt), .load_evt(load_evt), .load_val(load_val)
  );

  assign period = flag_q ? reload_q : TMO_PERIOD;

  wdt_tmo_counter #(.CNT_W(CNT_W), .CNT_INIT(RLD_INIT)) u_cnt (
    .clk(clk), .rst(rst), .load(load_evt), .load_val(load_val),
    .period(period), .expire(expire)
  );

  always_comb begin
    rd_next = '0;
    if (reg_addr == ADDR_W'(ADDR_CTRL0)) begin
      rd_next[BIT_FLAG]          = flag_q;
      rd_next[BIT_LOCK]          = !win_open;
      rd_next[BIT_ERR]           = err_q;
      rd_next[DATA_W-1:RLD_LSB]  = reload_q;
    end else if (reg_addr == ADDR_W'(ADDR_CTRL1)) begin
      rd_next[BIT_DR] = dr_q;
      rd_next[BIT_IR] = ir_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      rst_req   <= 1'b0;
    end else begin
      reg_rdata <= rd_next;
      rst_req   <= err_evt || expire;
    end
  end

  assign prot_lock = flag_q;

  assert_error_requests_reset_R5: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> rst_req);
  assert_lock_held_R7: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == ADDR_W'(ADDR_CTRL0)) |=> $stable(prot_lock));
endmodule

// File: tb/wdt_initlock_bench.sv
module wdt_initlock_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 2;
  localparam int unsigned TMO = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic prot_lock, rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wdt_initlock #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(16),
                 .RLD_INIT(16'hFFFF), .TMO_PERIOD(16'(TMO))) u_wdt_initlock (
    .clk(clk), .rst(rst), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .prot_lock(prot_lock), .rst_req(rst_req)
  );

  // {addr, wdata, exp flag, exp lock bit, exp err, exp rst_req pulse}
  localparam logic [37:0] VEC [17] = '{
    {2'd0, 32'h000000F0, 4'b1000},  // key, mirrors 00 (R2)
    {2'd0, 32'hFFFF00F2, 4'b0100},  // change, clear flag (R4)
    {2'd1, 32'h0000000C, 4'b0100},  // DR=IR=1 while flag 0 (R6)
    {2'd0, 32'h000000F0, 4'b0111},  // stale mirror key (R5)
    {2'd0, 32'h000000FC, 4'b0010},  // correct key (R2)
    {2'd0, 32'hFFFF00F3, 4'b1100},  // change, set flag, err cleared (R4)
    {2'd1, 32'h00000000, 4'b1100},  // ignored, flag 1 (R6)
    {2'd0, 32'h000000FC, 4'b1000},  // key
    {2'd0, 32'hFFFF00FB, 4'b1111},  // change with bits 3:2 nonzero (R5)
    {2'd0, 32'hFFFF00F2, 4'b1111},  // change without key (R5)
    {2'd0, 32'h000000FC, 4'b1010},  // key
    {2'd0, 32'h000000FC, 4'b1111},  // second key in window (R3 R5)
    {2'd0, 32'h000000FE, 4'b1111},  // key with bit1 set (R5)
    {2'd0, 32'h000000DC, 4'b1111},  // key with wrong nibble (R5)
    {2'd0, 32'h000000FC, 4'b1010},  // key
    {2'd2, 32'h00000000, 4'b1010},  // other address keeps window (R3)
    {2'd0, 32'hFFFF00F3, 4'b1100}   // change closes window (R3 R4)
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; addr = '0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  initial begin
    logic [DW-1:0] rd;
    logic rs;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 prot_lock", 32'(prot_lock), 32'd1);
    chk("R1 rst_req", 32'(rst_req), 32'd0);
    do_read(2'd0, rd);
    chk("R1 R10 ctrl0 reset", rd, 32'hFFFF0003);
    do_read(2'd1, rd);
    chk("R1 ctrl1 reset", rd, 32'h0);

    for (int i = 0; i < 17; i++) begin
      do_write(VEC[i][37:36], VEC[i][35:4]);
      rs = rst_req;
      do_read(2'd0, rd);
      chk($sformatf("R2 R3 R4 R5 vector %0d", i),
          {28'h0, rd[0], rd[1], rd[8], rs}, {28'h0, VEC[i][3:0]});
    end

    do_read(2'd1, rd);
    chk("R6 ctrl1 mirrors kept", rd, 32'h0000000C);
    do_read(2'd3, rd);
    chk("R10 unmapped reads zero", rd, 32'h0);
    do_read(2'd0, rd);
    chk("R10 ctrl0 layout", rd, 32'hFFFF0003);

    // time-out mode
    do_write(2'd0, 32'h000000FC);
    do_write(2'd0, 32'hFFFF00F2);
    chk("R7 prot_lock cleared", 32'(prot_lock), 32'd0);
    repeat (TMO) @(posedge clk);
    @(negedge clk);
    chk("R8 no pulse at edge TMO", 32'(rst_req), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R8 pulse at edge TMO+1", 32'(rst_req), 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R8 pulse one cycle", 32'(rst_req), 32'd0);

    // back to normal mode with reload 0x40
    do_write(2'd0, 32'h000000FC);
    do_write(2'd0, 32'h004000F3);
    chk("R7 prot_lock set", 32'(prot_lock), 32'd1);
    repeat (64) @(posedge clk);
    @(negedge clk);
    chk("R9 no pulse at edge N", 32'(rst_req), 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R9 pulse at edge N+1", 32'(rst_req), 32'd1);
    do_read(2'd0, rd);
    chk("R4 reload field stored", {16'h0, rd[31:16]}, 32'h00000040);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule